// File: doc/BRIEF.md
# ADC output test pattern generator

This block sits between a converter's sample path and its parallel output drivers. When no test pattern is selected it passes the sample words through. When a pattern is selected it replaces them, so that a receiver can check timing closure and the digital link. Two patterns are available. The toggle pattern drives every line to one, then every line to zero, on alternate words. The PRBS pattern comes from a 7-stage shift register with polynomial x^7 + x^6 + 1, and its single output bit is copied onto every line of the word.

The block drives two output buses, A and B, when dual-bus operation is enabled, and bus A alone otherwise. A three-state machine (PASS, TOGGLE, PRBS) follows a 2-bit mode code. Any state moves to any other on the clock edge that samples a new code:
- code 01 leads to TOGGLE.
- code 10 leads to PRBS.
- code 00 or 11 leads to PASS.

The toggle phase and the PRBS register advance only on words produced in their own state, and hold otherwise. The PRBS register has no reset, so the pattern starts at an arbitrary point of its 127-word period. A zero detector keeps that register out of the all-zero state. The parameter `B_ANTIPHASE` selects whether bus B toggles in phase with bus A or inverted from it.

Top module: `adc_tpg`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `bus_a` and `bus_b` are all zero. `out_valid` is 1 after the first rising edge with `rst_n` high, and it stays 1.
- R2: With mode code 00, `bus_a` (and `bus_b` when dual-bus is enabled) equals the sample word captured at the same rising edge.
- R3: Mode code 11 behaves exactly like code 00.
- R4: With mode code 01 held, consecutive words on `bus_a` alternate between all ones and all zeros.
- R5: In dual-bus toggle mode, `bus_b` equals `bus_a` when `B_ANTIPHASE` is 0, and equals its bitwise inverse when `B_ANTIPHASE` is 1.
- R6: With mode code 10 held, the per-word pattern bit o[n] satisfies o[n] = o[n-6] XOR o[n-7]. It repeats with a period of 127, and no seven consecutive bits are all zero.
- R7: In PRBS mode, every line of `bus_a` carries the same bit. With dual-bus enabled, `bus_b` equals `bus_a`.
- R8: With `dual_en` low, `bus_b` is all zeros in every mode.
- R9: The PRBS register holds while another mode is active. On return to PRBS mode the sequence continues from where it stopped.
- R10: The toggle phase holds while another mode is active. The first toggle word after a return is the inverse of the last toggle word emitted.
- R11: A change on `mode_sel` or `dual_en` is sampled at one rising edge and shows on the outputs at the next rising edge. The word registered at the sampling edge still follows the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output word clock |
| rst_n | input | 1 | Active-low synchronous reset (the PRBS register is not reset) |
| mode_sel | input | 2 | Pattern code: 00 pass, 01 toggle, 10 PRBS, 11 pass |
| dual_en | input | 1 | 1 drives both buses, 0 drives bus A only |
| samp_a | input | W | Sample word for bus A |
| samp_b | input | W | Sample word for bus B |
| bus_a | output | W | Registered word on bus A |
| bus_b | output | W | Registered word on bus B |
| out_valid | output | 1 | High once the output registers hold a word |

## Verification
The hardest part to check is the PRBS mode. The register starts at an unknown point, and it must resume correctly after a detour through other modes. Neither can be seen directly from the ports. The bench therefore learns the first seven pattern bits it sees and predicts every later bit with the recurrence. It runs well past one full 127-word period so that periodicity and the absence of a zero run are covered. It then leaves PRBS mode for several words and re-enters it, keeping its bit history and requiring the recurrence to hold across the gap. The toggle detour is checked the same way: the last toggle word before leaving is recorded, and the first word after returning must be its inverse.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic [1:0] {
        MD_PASS   = 2'b00,
        MD_TOGGLE = 2'b01,
        MD_PRBS   = 2'b10,
        MD_ALTP   = 2'b11
    } mode_code_e;

    typedef enum logic [1:0] {
        ST_PASS   = 2'b00,
        ST_TOGGLE = 2'b01,
        ST_PRBS   = 2'b10
    } tpg_state_e;

    localparam int unsigned PRBS_STAGES = 7;
    localparam logic [PRBS_STAGES-1:0] PRBS_ESCAPE = 7'h01;

    function automatic tpg_state_e decode_mode(input logic [1:0] code);
        tpg_state_e s;
        unique case (mode_code_e'(code))
            MD_TOGGLE: s = ST_TOGGLE;
            MD_PRBS:   s = ST_PRBS;
            default:   s = ST_PASS;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tpg_mode_fsm.sv
module tpg_mode_fsm
    import tpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       dual_en,
    output tpg_state_e state_o,
    output logic       dual_o,
    output logic       tog_adv,
    output logic       prbs_adv
);

    tpg_state_e st_q;
    tpg_state_e st_d;
    logic       dual_q;

    always_comb begin
        st_d = decode_mode(mode_sel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_PASS;
            dual_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            dual_q <= dual_en;
        end
    end

    always_comb begin
        tog_adv  = 1'b0;
        prbs_adv = 1'b0;
        unique case (st_q)
            ST_PASS:   ;
            ST_TOGGLE: tog_adv  = 1'b1;
            ST_PRBS:   prbs_adv = 1'b1;
            default:   ;
        endcase
    end

    assign state_o = st_q;
    assign dual_o  = dual_q;

    // R11: the state follows the code seen at the previous edge
    a_r11_state_follows_code: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (st_q == decode_mode($past(mode_sel))));

    a_r11_one_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !(tog_adv && prbs_adv));

endmodule

// File: rtl/tpg_toggle.sv
module tpg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic phase_o
);

    logic ph_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= 1'b0;
        end else if (adv) begin
            ph_q <= ~ph_q;
        end
    end

    assign phase_o = ph_q;

    // R4: phase flips on every advancing word
    a_r4_phase_flips: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (ph_q != $past(ph_q)));

    // R10: phase frozen outside toggle mode
    a_r10_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ph_q));

endmodule

// File: rtl/tpg_prbs7.sv
module tpg_prbs7
    import tpg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic bit_o
);

    localparam int unsigned MSB = PRBS_STAGES - 1;

    logic [MSB:0] sr_q;
    logic [MSB:0] sr_d;
    logic         fb;
    logic         stuck;

    always_comb begin
        fb    = sr_q[MSB] ^ sr_q[MSB-1];
        stuck = (sr_q == '0);
        if (stuck) begin
            sr_d = PRBS_ESCAPE;
        end else if (adv) begin
            sr_d = {sr_q[MSB-1:0], fb};
        end else begin
            sr_d = sr_q;
        end
    end

    always_ff @(posedge clk) begin
        sr_q <= sr_d;
    end

    assign bit_o = sr_q[MSB];

    // R6: all-zero state is left at the next edge
    a_r6_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_q == '0) |=> (sr_q != '0));

    // R6: the register shifts toward the MSB on each advancing word
    a_r6_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && sr_q != '0) |=> (sr_q[MSB:1] == $past(sr_q[MSB-1:0])));

    // R9: the register holds when not advancing
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && sr_q != '0) |=> $stable(sr_q));

endmodule

// File: rtl/adc_tpg.sv
module adc_tpg
    import tpg_pkg::*;
#(
    parameter int unsigned W           = 8,
    parameter bit          B_ANTIPHASE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode_sel,
    input  logic         dual_en,
    input  logic [W-1:0] samp_a,
    input  logic [W-1:0] samp_b,
    output logic [W-1:0] bus_a,
    output logic [W-1:0] bus_b,
    output logic         out_valid
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    tpg_state_e   st;
    logic         dual_q;
    logic         tog_adv;
    logic         prbs_adv;
    logic         phase;
    logic         pbit;
    logic [W-1:0] tog_word_a;
    logic [W-1:0] tog_word_b;
    logic [W-1:0] prbs_word;

    logic [W-1:0] a_q;
    logic [W-1:0] b_q;
    logic         valid_q;
    tpg_state_e   kind_q;
    logic         dual_out_q;

    tpg_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .dual_en  (dual_en),
        .state_o  (st),
        .dual_o   (dual_q),
        .tog_adv  (tog_adv),
        .prbs_adv (prbs_adv)
    );

    tpg_toggle u_tog (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (tog_adv),
        .phase_o (phase)
    );

    tpg_prbs7 u_prbs (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (prbs_adv),
        .bit_o (pbit)
    );

    assign tog_word_a = {W{phase}};
    assign prbs_word  = {W{pbit}};

    generate
        if (B_ANTIPHASE) begin : g_b_anti
            assign tog_word_b = ~tog_word_a;
        end else begin : g_b_inphase
            assign tog_word_b = tog_word_a;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q        <= '0;
            b_q        <= '0;
            valid_q    <= 1'b0;
            kind_q     <= ST_PASS;
            dual_out_q <= 1'b0;
        end else begin
            valid_q    <= 1'b1;
            kind_q     <= st;
            dual_out_q <= dual_q;
            unique case (st)
                ST_TOGGLE: begin
                    a_q <= tog_word_a;
                    b_q <= dual_q ? tog_word_b : '0;
                end
                ST_PRBS: begin
                    a_q <= prbs_word;
                    b_q <= dual_q ? prbs_word : '0;
                end
                default: begin
                    a_q <= samp_a;
                    b_q <= dual_q ? samp_b : '0;
                end
            endcase
        end
    end

    assign bus_a     = a_q;
    assign bus_b     = b_q;
    assign out_valid = valid_q;

    // R1: valid never drops once raised outside reset
    a_r1_valid_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);

    // R4: steady toggle words alternate
    a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == ST_TOGGLE) |=> ((kind_q == ST_TOGGLE) -> (bus_a == ~$past(bus_a))));

    // R4/R7: pattern words are uniform across lines
    a_r7_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q != ST_PASS) |-> (bus_a == '0 || bus_a == ALL_ONES));

    // R5: bus B relation in dual toggle mode
    a_r5_b_relation: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == ST_TOGGLE && dual_out_q) |->
            (bus_b == (B_ANTIPHASE ? ~bus_a : bus_a)));

    // R7: bus B copies bus A in dual PRBS mode
    a_r7_b_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == ST_PRBS && dual_out_q) |-> (bus_b == bus_a));

    // R8: single-bus mode keeps bus B quiet
    a_r8_b_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !dual_out_q) |-> (bus_b == '0));

endmodule

// File: tb/adc_tpg_tb.sv
module adc_tpg_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam bit ANTI       = 1'b1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   mode_sel;
    logic         dual_en;
    logic [W-1:0] samp_a;
    logic [W-1:0] samp_b;
    logic [W-1:0] bus_a;
    logic [W-1:0] bus_b;
    logic         out_valid;

    int n_chk = 0;
    int n_err = 0;
    bit hist [0:1023];
    int hn = 0;
    logic [W-1:0] last_tog;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_tpg #(.W(W), .B_ANTIPHASE(ANTI)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .dual_en   (dual_en),
        .samp_a    (samp_a),
        .samp_b    (samp_b),
        .bus_a     (bus_a),
        .bus_b     (bus_b),
        .out_valid (out_valid)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic bit uniform(input logic [W-1:0] v);
        return (v == '0) || (v == {W{1'b1}});
    endfunction

    task automatic take_prbs(input bit dual);
        bit b;
        b = bus_a[0];
        check(uniform(bus_a), "R7 lines equal", bus_a, {W{b}});
        if (dual) check(bus_b == bus_a, "R7 bus B copy", bus_b, bus_a);
        else      check(bus_b == '0, "R8 B quiet in PRBS", bus_b, 0);
        hist[hn] = b;
        if (hn >= 7)
            check(hist[hn] == (hist[hn-6] ^ hist[hn-7]), "R6/R9 recurrence", hist[hn], hist[hn-6] ^ hist[hn-7]);
        if (hn >= 127)
            check(hist[hn] == hist[hn-127], "R6 period 127", hist[hn], hist[hn-127]);
        if (hn >= 6) begin
            bit any;
            any = 1'b0;
            for (int k = 0; k < 7; k++) any |= hist[hn-k];
            check(any, "R6 no zero run", 0, 1);
        end
        hn++;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        mode_sel = 2'b00;
        dual_en  = 1'b1;
        samp_a   = 8'h3C;
        samp_b   = 8'hA5;
        tick; tick; tick;
        // R1: reset state
        check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
        check(bus_a == '0, "R1 bus A in reset", bus_a, 0);
        check(bus_b == '0, "R1 bus B in reset", bus_b, 0);
        rst_n = 1'b1;
        tick;
        check(out_valid == 1'b1, "R1 valid after reset", out_valid, 1);

        // R2: pass-through sweep, dual bus
        tick;
        for (int i = 0; i < 256; i++) begin
            samp_a = W'(i);
            samp_b = W'((i * 37 + 11) & 8'hFF);
            tick;
            check(bus_a == samp_a, "R2 bus A data", bus_a, samp_a);
            check(bus_b == samp_b, "R2 bus B data", bus_b, samp_b);
            check(out_valid == 1'b1, "R1 valid stays", out_valid, 1);
        end

        // R3: code 11 same as pass
        mode_sel = 2'b11;
        tick; tick;
        for (int i = 0; i < 64; i++) begin
            samp_a = W'(i * 5 + 1);
            samp_b = W'(~(i * 3));
            tick;
            check(bus_a == samp_a, "R3 alt code bus A", bus_a, samp_a);
            check(bus_b == samp_b, "R3 alt code bus B", bus_b, samp_b);
        end

        // R8: single bus in pass mode, with R11 latency on dual_en
        mode_sel = 2'b00;
        dual_en  = 1'b0;
        samp_a = 8'h5A; samp_b = 8'hC3;
        tick;
        check(bus_b == 8'hC3, "R11 dual change not yet seen", bus_b, 8'hC3);
        tick;
        check(bus_b == '0, "R8 B quiet in pass", bus_b, 0);
        check(bus_a == 8'h5A, "R8 A still driven", bus_a, 8'h5A);

        // R11: mode change latency, then R4/R5 toggle
        dual_en  = 1'b1;
        samp_a   = 8'h69;
        mode_sel = 2'b01;
        tick;
        check(bus_a == 8'h69, "R11 old mode on sampling edge", bus_a, 8'h69);
        tick;
        check(uniform(bus_a), "R11 toggle word after latency", bus_a, 8'hFF);
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] prev;
            prev = bus_a;
            tick;
            check(uniform(bus_a), "R4 uniform toggle", bus_a, {W{bus_a[0]}});
            check(bus_a == ~prev, "R4 alternation", bus_a, ~prev);
            check(bus_b == (ANTI ? ~bus_a : bus_a), "R5 bus B phase", bus_b, ANTI ? ~bus_a : bus_a);
        end

        // R10: leave toggle and come back
        mode_sel = 2'b00;
        samp_a   = 8'h81;
        tick;
        last_tog = bus_a;
        check(uniform(last_tog), "R11 last toggle word", last_tog, {W{last_tog[0]}});
        for (int i = 0; i < 5; i++) begin
            samp_a = W'(8'h10 + i);
            tick;
            check(bus_a == samp_a, "R2 pass between patterns", bus_a, samp_a);
        end
        mode_sel = 2'b01;
        tick; tick;
        check(bus_a == ~last_tog, "R10 toggle resumes", bus_a, ~last_tog);

        // R8: toggle with single bus
        dual_en = 1'b0;
        tick; tick;
        for (int i = 0; i < 6; i++) begin
            tick;
            check(bus_b == '0, "R8 B quiet in toggle", bus_b, 0);
        end

        // R6/R7: PRBS, more than two periods
        dual_en  = 1'b1;
        mode_sel = 2'b10;
        tick; tick;
        take_prbs(1'b1);
        for (int i = 0; i < 299; i++) begin
            tick;
            take_prbs(1'b1);
        end

        // R9: detour through pass, then resume
        mode_sel = 2'b00;
        samp_a   = 8'h42;
        tick;
        take_prbs(1'b1);
        for (int i = 0; i < 6; i++) begin
            samp_a = W'(8'h20 + i);
            tick;
            check(bus_a == samp_a, "R9 pass during detour", bus_a, samp_a);
        end
        mode_sel = 2'b10;
        tick; tick;
        take_prbs(1'b1);
        for (int i = 0; i < 20; i++) begin
            tick;
            take_prbs(1'b1);
        end

        // R9: detour through toggle, single bus on return
        mode_sel = 2'b01;
        tick;
        take_prbs(1'b1);
        tick; tick; tick;
        mode_sel = 2'b10;
        dual_en  = 1'b0;
        tick; tick;
        take_prbs(1'b0);
        for (int i = 0; i < 140; i++) begin
            tick;
            take_prbs(1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule